// File: doc/BRIEF.md
# Processor Address Router with Relocatable Tightly-Coupled Windows

This block sits on the bus of a 32-bit processor. It decides which target an access reaches. Each access carries an address, a direction and a width. The router selects one of nine targets and produces a masked local offset. If no target applies, it raises an unmapped flag instead.

The nine targets are:
- instruction tightly-coupled memory (ITCM)
- data tightly-coupled memory (DTCM)
- main RAM
- a banked shared RAM
- I/O space
- palette
- VRAM
- OAM
- boot ROM

The two tightly-coupled windows can be resized at run time, and the data window can also be moved. Both windows take priority over the fixed regions. A per-window load mode sends writes to the tightly-coupled memory, while reads fall through to whatever lies underneath.

Configuration arrives through a small write-only port. The port has four registers:
- ITCM settings
- DTCM settings
- a control word holding the two load-mode bits
- the shared-RAM bank mode

Each access is registered: the decision for an access presented on one rising edge appears on the outputs after that edge, qualified by `out_valid`.

Top module: `tcm_addr_router`

## Requirements
- R1: The fixed region is chosen by address bits [31:24]:
  - 0x02 selects main RAM, with offset address[21:0].
  - 0x04 selects I/O, 0x05 selects palette, 0x06 selects VRAM and 0x07 selects OAM; each of these four uses offset address[23:0].
  - Any other value that no rule claims is unmapped.
- R2: Region 0xFF selects the boot ROM with offset address[11:0], for reads only. A write there is unmapped.
- R3: The ITCM window (config register 0) works as follows:
  - It starts at address 0.
  - Bit 0 of the register enables it.
  - Its size is 512 bytes shifted left by bits [5:1], rounded up to whole 4 KiB pages.
  - The local offset is address[14:0], so 32 KiB repeats across the window.
- R4: The DTCM window (config register 1) works as follows:
  - Bit 0 enables it.
  - Its base is bits [31:12].
  - Its size follows the same rule as the ITCM window.
  - The local offset is address[13:0].
  - The window never wraps past the top of the address space.
- R5: ITCM has priority over DTCM, and DTCM has priority over the fixed regions.
- R6: Bit 19 of config register 2 is the ITCM load mode, and bit 17 is the DTCM load mode. With a load mode set, writes inside that window still go to the TCM. Reads inside the window fall through to the next lower-priority target.
- R7: Region 0x03 is shared RAM, governed by config register 3, bits [1:0]:
  - Mode 0 uses offset address[14:0].
  - Mode 1 uses address[13:0] plus 0x4000.
  - Mode 2 uses address[13:0].
  - Mode 3 leaves the region unmapped for both reads and writes.
- R8: Addresses 0x04000320 through 0x040006A3 accept only 32-bit accesses (size code 2). Byte accesses (code 0) and halfword accesses (code 1) there are unmapped.
- R9: On a valid result:
  - Exactly one select bit is set and the unmapped flag is low, or no select bit is set and the unmapped flag is high.
  - An unmapped result carries offset 0.
- R10: Timing:
  - An access sampled on a rising edge produces its result after that edge, with `out_valid` high for exactly one cycle.
  - A configuration write applies to accesses sampled on any later edge.
- R11: After reset:
  - Both windows are disabled and the DTCM base is 0.
  - Both load modes are clear and the shared mode is 0.
  - `out_valid` and all select bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Config register: 0 ITCM, 1 DTCM, 2 control, 3 shared mode |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Access address |
| out_valid | output | 1 | Result valid |
| tgt_sel | output | 9 | One-hot target: bit 0 ITCM, 1 DTCM, 2 main, 3 shared, 4 I/O, 5 palette, 6 VRAM, 7 OAM, 8 boot |
| tgt_offset | output | 32 | Masked local offset |
| tgt_unmapped | output | 1 | No target accepted the access |

## Verification
The bench targets the edges of both windows:
- It probes the last byte inside a window and the first byte outside it. An off-by-one in the page comparison would misroute one of the two.
- It uses a 512-byte setting to prove that a window rounds up to a full page.
- It places the data window on the top page with the largest size. A design whose comparison wraps would then claim address 0 as well.

Overlapping windows are checked with and without load modes. A design that ignores direction would send load-mode writes to the region underneath. A design that skips the fall-through order would bypass the data window for reads.

All four shared-RAM modes and all three widths around the word-only I/O range are driven. An inclusive upper bound or a reversed width test shows up there as a wrong select bit.

// File: rtl/tcm_addr_router.sv
module tcm_addr_router #(
  parameter int          ITCM_OFS_BITS = 15,
  parameter int          DTCM_OFS_BITS = 14,
  parameter int          MAIN_OFS_BITS = 22,
  parameter int          BOOT_OFS_BITS = 12,
  parameter int          SHR_HALF_BITS = 14,
  parameter int          PAGE_BITS     = 12,
  parameter logic [31:0] WORD_ONLY_LO  = 32'h0400_0320,
  parameter logic [31:0] WORD_ONLY_HI  = 32'h0400_06A4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_addr,
  output logic        out_valid,
  output logic [8:0]  tgt_sel,
  output logic [31:0] tgt_offset,
  output logic        tgt_unmapped
);
  localparam int T_ITCM = 0, T_DTCM = 1, T_MAIN = 2, T_SHR = 3, T_IO = 4;
  localparam int T_PAL = 5, T_VRAM = 6, T_OAM = 7, T_BOOT = 8;
  localparam int PN_W  = 32 - PAGE_BITS;
  localparam int CNT_W = PN_W + 9;
  localparam int PG_SHIFT = PAGE_BITS - 9;

  logic             it_en, dt_en, it_load, dt_load;
  logic [4:0]       it_code, dt_code;
  logic [PN_W-1:0]  dt_page;
  logic [1:0]       sh_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      it_en <= 1'b0; it_code <= '0;
      dt_en <= 1'b0; dt_code <= '0; dt_page <= '0;
      it_load <= 1'b0; dt_load <= 1'b0;
      sh_mode <= 2'd0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin it_en <= cfg_wdata[0]; it_code <= cfg_wdata[5:1]; end
        2'd1: begin
          dt_en   <= cfg_wdata[0];
          dt_code <= cfg_wdata[5:1];
          dt_page <= cfg_wdata[31:PAGE_BITS];
        end
        2'd2: begin it_load <= cfg_wdata[19]; dt_load <= cfg_wdata[17]; end
        default: sh_mode <= cfg_wdata[1:0];
      endcase
    end
  end

  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata;

  function automatic logic [CNT_W-1:0] page_count(input logic [4:0] code);
    if (code < 5'(PG_SHIFT)) return CNT_W'(1);
    return CNT_W'(1) << (code - 5'(PG_SHIFT));
  endfunction

  logic [PN_W-1:0] a_page, d_rel;
  logic it_hit, dt_hit, it_take, dt_take, in_word_only;
  assign a_page  = acc_addr[31:PAGE_BITS];
  assign d_rel   = a_page - dt_page;
  assign it_hit  = it_en && ({9'b0, a_page} < page_count(it_code));
  assign dt_hit  = dt_en && (a_page >= dt_page) && ({9'b0, d_rel} < page_count(dt_code));
  assign it_take = it_hit && (acc_write || !it_load);
  assign dt_take = dt_hit && (acc_write || !dt_load);
  assign in_word_only = (acc_addr >= WORD_ONLY_LO) && (acc_addr < WORD_ONLY_HI);

  logic [8:0]  n_sel;
  logic [31:0] n_off;

  always_comb begin
    n_sel = '0;
    n_off = '0;
    if (it_take) begin
      n_sel[T_ITCM] = 1'b1;
      n_off = {{(32-ITCM_OFS_BITS){1'b0}}, acc_addr[ITCM_OFS_BITS-1:0]};
    end else if (dt_take) begin
      n_sel[T_DTCM] = 1'b1;
      n_off = {{(32-DTCM_OFS_BITS){1'b0}}, acc_addr[DTCM_OFS_BITS-1:0]};
    end else begin
      case (acc_addr[31:24])
        8'h02: begin
          n_sel[T_MAIN] = 1'b1;
          n_off = {{(32-MAIN_OFS_BITS){1'b0}}, acc_addr[MAIN_OFS_BITS-1:0]};
        end
        8'h03: begin
          case (sh_mode)
            2'd0: begin
              n_sel[T_SHR] = 1'b1;
              n_off = {{(31-SHR_HALF_BITS){1'b0}}, acc_addr[SHR_HALF_BITS:0]};
            end
            2'd1: begin
              n_sel[T_SHR] = 1'b1;
              n_off = {{(31-SHR_HALF_BITS){1'b0}}, 1'b1, acc_addr[SHR_HALF_BITS-1:0]};
            end
            2'd2: begin
              n_sel[T_SHR] = 1'b1;
              n_off = {{(32-SHR_HALF_BITS){1'b0}}, acc_addr[SHR_HALF_BITS-1:0]};
            end
            default: ;
          endcase
        end
        8'h04: begin
          if (!in_word_only || acc_size == 2'd2) begin
            n_sel[T_IO] = 1'b1;
            n_off = {8'h00, acc_addr[23:0]};
          end
        end
        8'h05: begin n_sel[T_PAL]  = 1'b1; n_off = {8'h00, acc_addr[23:0]}; end
        8'h06: begin n_sel[T_VRAM] = 1'b1; n_off = {8'h00, acc_addr[23:0]}; end
        8'h07: begin n_sel[T_OAM]  = 1'b1; n_off = {8'h00, acc_addr[23:0]}; end
        8'hFF: begin
          if (!acc_write) begin
            n_sel[T_BOOT] = 1'b1;
            n_off = {{(32-BOOT_OFS_BITS){1'b0}}, acc_addr[BOOT_OFS_BITS-1:0]};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      tgt_sel      <= '0;
      tgt_offset   <= '0;
      tgt_unmapped <= 1'b0;
    end else begin
      out_valid    <= acc_valid;
      tgt_sel      <= acc_valid ? n_sel : '0;
      tgt_offset   <= acc_valid ? n_off : '0;
      tgt_unmapped <= acc_valid && (n_sel == '0);
    end
  end

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  // R9
  unmapped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tgt_unmapped == ($countones(tgt_sel) == 0)));
  // R2
  boot_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !tgt_sel[T_BOOT]);
  // R3
  itcm_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_ITCM] |-> (tgt_offset[31:ITCM_OFS_BITS] == '0));
  // R4
  dtcm_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_DTCM] |-> (tgt_offset[31:DTCM_OFS_BITS] == '0));
  // R8
  word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_word_only && acc_size != 2'd2) |=> !tgt_sel[T_IO]);
  // R7
  shared_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sh_mode == 2'd3 && acc_addr[31:24] == 8'h03) |=> !tgt_sel[T_SHR]);
  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid);
endmodule

// File: tb/tcm_addr_router_tb.sv
`timescale 1ns/1ps
module tcm_addr_router_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [1:0] cfg_sel = '0; logic [31:0] cfg_wdata = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0; logic [1:0] acc_size = '0; logic [31:0] acc_addr = '0;
  logic out_valid, tgt_unmapped; logic [8:0] tgt_sel; logic [31:0] tgt_offset;

  always #2 clk = ~clk;

  tcm_addr_router u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .acc_valid, .acc_write,
    .acc_size, .acc_addr, .out_valid, .tgt_sel, .tgt_offset, .tgt_unmapped);

  localparam int NONE = -1, ITCM = 0, DTCM = 1, MAIN = 2, SHR = 3, IO = 4, PAL = 5, VRAM = 6, OAM = 7, BOOT = 8;
  localparam logic RD = 1'b0, WR = 1'b1;

  typedef struct { logic [8:0] sel; logic [31:0] off; logic unm; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic acc(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                     input int t, input logic [31:0] off, input string tag);
    exp_t e;
    e.sel = (t < 0) ? 9'd0 : (9'd1 << t);
    e.off = (t < 0) ? 32'd0 : off;
    e.unm = (t < 0);
    e.tag = tag;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = a;
    exp_q.push_back(e);
    @(negedge clk); acc_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result", "none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(tgt_sel == e.sel && tgt_offset == e.off && tgt_unmapped == e.unm, e.tag,
              $sformatf("sel=%03h off=%08h unm=%0b", tgt_sel, tgt_offset, tgt_unmapped),
              $sformatf("sel=%03h off=%08h unm=%0b", e.sel, e.off, e.unm));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "watchdog", "timeout", "completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs idle during and just after reset
    check(out_valid == 1'b0 && tgt_sel == '0, "R11",
          $sformatf("v=%0b sel=%03h", out_valid, tgt_sel), "v=0 sel=000");
    rst_n = 1'b1;
    // R11: windows disabled after reset, shared mode 0
    acc(RD, 2, 32'h0000_0100, NONE, 0, "R11 itcm off");
    acc(RD, 2, 32'h0300_ABCD, SHR, 32'h2BCD, "R11 shared mode0");
    // R1 fixed regions
    acc(RD, 2, 32'h02AB_CDEF, MAIN, 32'h002B_CDEF, "R1 main");
    acc(WR, 1, 32'h0500_1234, PAL, 32'h0000_1234, "R1 palette");
    acc(WR, 0, 32'h0601_2345, VRAM, 32'h0001_2345, "R1 vram");
    acc(RD, 2, 32'h0700_0400, OAM, 32'h0000_0400, "R1 oam");
    acc(RD, 1, 32'h0400_0130, IO, 32'h0000_0130, "R1 io");
    acc(RD, 2, 32'h0800_0000, NONE, 0, "R1/R9 unmapped");
    // R2 boot ROM
    acc(RD, 2, 32'hFF00_0ABC, BOOT, 32'h0000_0ABC, "R2 boot read");
    acc(RD, 0, 32'hFFFF_F123, BOOT, 32'h0000_0123, "R2 boot read high");
    acc(WR, 2, 32'hFF00_0ABC, NONE, 0, "R2 boot write");
    // R7 shared modes
    cfg(3, 1);
    acc(RD, 2, 32'h0300_ABCD, SHR, 32'h6BCD, "R7 mode1");
    cfg(3, 2);
    acc(WR, 2, 32'h0300_ABCD, SHR, 32'h2BCD, "R7 mode2");
    cfg(3, 3);
    acc(RD, 2, 32'h0300_ABCD, NONE, 0, "R7 mode3 read");
    acc(WR, 2, 32'h0300_0000, NONE, 0, "R7 mode3 write");
    cfg(3, 0);
    acc(RD, 2, 32'h0300_7FFF, SHR, 32'h7FFF, "R7 mode0");
    // R8 word-only range
    acc(RD, 2, 32'h0400_0320, IO, 32'h0000_0320, "R8 word read");
    acc(WR, 2, 32'h0400_06A0, IO, 32'h0000_06A0, "R8 word write");
    acc(RD, 0, 32'h0400_0320, NONE, 0, "R8 byte read");
    acc(WR, 1, 32'h0400_0400, NONE, 0, "R8 half write");
    acc(RD, 0, 32'h0400_06A3, NONE, 0, "R8 last byte");
    acc(RD, 0, 32'h0400_06A4, IO, 32'h0000_06A4, "R8 above range");
    acc(RD, 1, 32'h0400_031E, IO, 32'h0000_031E, "R8 below range");
    // R3 ITCM window
    cfg(0, 32'h0000_000D);
    acc(RD, 2, 32'h0000_7FFC, ITCM, 32'h7FFC, "R3 32K inside");
    acc(RD, 2, 32'h0000_8000, NONE, 0, "R3 32K outside");
    cfg(0, 32'h0000_0011);
    acc(WR, 2, 32'h0001_2345, ITCM, 32'h2345, "R3 128K mirror");
    acc(RD, 2, 32'h0002_0000, NONE, 0, "R3 128K outside");
    cfg(0, 32'h0000_0001);
    acc(RD, 0, 32'h0000_0FFF, ITCM, 32'h0FFF, "R3 page rounding");
    acc(RD, 0, 32'h0000_1000, NONE, 0, "R3 page edge");
    cfg(0, 32'h0000_000C);
    acc(RD, 0, 32'h0000_0000, NONE, 0, "R3 enable clear");
    // R4 DTCM window
    cfg(1, 32'h0280_000B);
    acc(WR, 2, 32'h0280_3FF0, DTCM, 32'h3FF0, "R4 inside");
    acc(RD, 2, 32'h0280_4000, MAIN, 32'h0000_4000, "R4 above");
    acc(RD, 2, 32'h027F_FFFC, MAIN, 32'h003F_FFFC, "R4 below");
    cfg(1, 32'h0280_000F);
    acc(RD, 2, 32'h0280_A123, DTCM, 32'h2123, "R4 mirror");
    cfg(1, 32'hFFFF_F03F);
    acc(RD, 2, 32'hFFFF_F800, DTCM, 32'h3800, "R4/R5 top page over boot");
    acc(RD, 2, 32'h0000_0000, NONE, 0, "R4 no wrap");
    // R5 priority
    cfg(0, 32'h0000_0011);
    cfg(1, 32'h0001_000B);
    acc(RD, 2, 32'h0001_1000, ITCM, 32'h1000, "R5 overlap itcm");
    cfg(0, 32'h0000_000D);
    acc(RD, 2, 32'h0001_1000, DTCM, 32'h1000, "R5 dtcm beyond itcm");
    // R6 load modes
    cfg(0, 32'h0000_0011);
    cfg(2, 32'h0008_0000);
    acc(RD, 2, 32'h0001_1000, DTCM, 32'h1000, "R6 itcm load read");
    acc(WR, 2, 32'h0001_1000, ITCM, 32'h1000, "R6 itcm load write");
    acc(RD, 2, 32'h0000_2000, NONE, 0, "R6 itcm load read fixed");
    cfg(2, 32'h000A_0000);
    acc(RD, 2, 32'h0001_1000, NONE, 0, "R6 both load read");
    acc(WR, 1, 32'h0001_1000, ITCM, 32'h1000, "R6 both load write");
    cfg(0, 32'h0000_0000);
    cfg(1, 32'h0280_000B);
    cfg(2, 32'h0002_0000);
    acc(RD, 2, 32'h0280_0010, MAIN, 32'h0000_0010, "R6 dtcm load read");
    acc(WR, 2, 32'h0280_0010, DTCM, 32'h0010, "R6 dtcm load write");
    repeat (4) @(negedge clk);
    // R10: every expected result consumed, output idle afterwards
    check(exp_q.size() == 0 && out_valid == 1'b0, "R10",
          $sformatf("pending=%0d v=%0b", exp_q.size(), out_valid), "pending=0 v=0");
    done = 1'b1;
    finish_run();
  end
endmodule